// File: doc/BRIEF.md
# Accumulator and Index Register Processor Core

This block is a small 8-bit processor core. It has an accumulator, an index register, an 11-bit program counter and three condition flags: zero, negative and carry. Every instruction is two bytes long. The first byte selects an operation, an addressing mode and the top three address bits. The second byte holds the low eight address bits, or immediate data, or a signed displacement. The core reaches a 2K-byte space through a single byte-wide synchronous memory port. Read data appears one clock after the address is presented, and a write completes on the clock edge at which the write enable is high.

The core runs each instruction as a short sequence of states: opcode fetch, operand fetch, address or execute, and an optional data read. An instruction that takes its operand from memory needs four cycles. All other instructions take three. Branches choose a flag to test from the mode field and never change any flag. Stores never change any flag.

Top module: `cpu8_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the index register, all three flags and the program counter. No write is issued while reset is held. The first opcode fetch after reset presents address 0.
- R2: Opcode bits 7:5 select the operation: 0 load accumulator, 1 load index, 2 add to accumulator, 3 NOR into accumulator, 4 store accumulator, 5 store index, 6 conditional branch, 7 jump. Bits 4:3 select the mode (0 immediate, 1 absolute, 2 indexed, 3 relative). Bits 2:0 are address bits 10:8. The operand byte follows the opcode at the next address, and a non-branching instruction is followed by the one two bytes later, modulo 2K.
- R3: The opcode address is presented in the first cycle and the operand address in the second. An instruction that reads a memory operand (operations 0 to 3 in a mode other than immediate) takes 4 cycles. Every other instruction takes 3 cycles.
- R4: Absolute address = {opcode[2:0], operand}. Indexed address = absolute + zero-extended index, modulo 2K. Relative address = (address of the instruction + 2) + sign-extended operand, modulo 2K. In immediate mode the operand byte itself is the data.
- R5: Load accumulator and load index copy the data into their register. Z is set when the loaded value is 0, N is set to bit 7 of the loaded value, and C is unchanged.
- R6: Add sets the accumulator to (accumulator + data) mod 256. C is set to the carry out of bit 7, and Z and N follow the result.
- R7: NOR sets the accumulator to the bitwise NOT of (accumulator OR data). Z and N follow the result and C is unchanged.
- R8: A store in a non-immediate mode drives the write enable in its third cycle, with the effective address and the register value. A store in immediate mode writes nothing and changes no register or flag. No store changes a flag.
- R9: A conditional branch jumps to the relative target (opcode bits 2:0 are ignored) when its condition holds. The condition is chosen by the mode field: 0 always, 1 Z set, 2 N set, 3 C clear. Flags are unchanged whether or not the branch is taken.
- R10: A jump loads the program counter with the effective address of its mode, and immediate mode is treated as absolute. Flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 11 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable for the current address |

## Verification
The hardest cases to reach from the ports are the address wrap-arounds. One is an indexed access whose sum passes the top of the 2K space. The other is a backward relative branch taken from near address 0. Both need the index register and the flags set up by earlier instructions. Directed programs build exactly these register and flag states before the wrapping instruction executes. Long runs over fully random memory images then reach every operation, mode and branch outcome, with self-modifying stores included. Each fetch address and each write is compared against an instruction-level model, cycle by cycle.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    typedef enum logic [2:0] {
        OP_LDA = 3'd0,
        OP_LDX = 3'd1,
        OP_ADD = 3'd2,
        OP_NOR = 3'd3,
        OP_STA = 3'd4,
        OP_STX = 3'd5,
        OP_BRC = 3'd6,
        OP_JMP = 3'd7
    } op_e;

    // Mode field; for conditional branches the same two bits pick the test.
    typedef enum logic [1:0] {
        MD_IMM = 2'd0,
        MD_ABS = 2'd1,
        MD_IDX = 2'd2,
        MD_REL = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_OPCODE = 2'd1,
        ST_ADDR   = 2'd2,
        ST_DATA   = 2'd3
    } state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
    } flags_t;

endpackage

// File: rtl/cpu8_agu.sv
module cpu8_agu
    import cpu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 11
) (
    input  mode_e              mode,
    input  logic [ADDR_W-DATA_W-1:0] hi_bits,
    input  logic [DATA_W-1:0]  lo_byte,
    input  logic [DATA_W-1:0]  index,
    input  logic [ADDR_W-1:0]  next_pc,
    output logic [ADDR_W-1:0]  ea,
    output logic [ADDR_W-1:0]  rel_target
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] abs_addr;
    logic [ADDR_W-1:0] idx_addr;

    always_comb begin
        abs_addr   = {hi_bits, lo_byte};
        idx_addr   = abs_addr + {{HI_W{1'b0}}, index};
        rel_target = next_pc + {{HI_W{lo_byte[DATA_W-1]}}, lo_byte};
        case (mode)
            MD_IDX:  ea = idx_addr;
            MD_REL:  ea = rel_target;
            default: ea = abs_addr;
        endcase
    end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic              c_in,
    output logic [DATA_W-1:0] result,
    output logic              c_out,
    output logic              wr_acc,
    output logic              wr_idx
);
    always_comb begin
        result = operand;
        c_out  = c_in;
        wr_acc = 1'b0;
        wr_idx = 1'b0;
        case (op)
            OP_LDA: wr_acc = 1'b1;
            OP_LDX: wr_idx = 1'b1;
            OP_ADD: begin
                {c_out, result} = {1'b0, acc} + {1'b0, operand};
                wr_acc = 1'b1;
            end
            OP_NOR: begin
                result = ~(acc | operand);
                wr_acc = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu8_cond.sv
module cpu8_cond
    import cpu8_pkg::*;
(
    input  mode_e  sel,
    input  flags_t flags,
    output logic   take
);
    always_comb begin
        case (sel)
            MD_IMM:  take = 1'b1;
            MD_ABS:  take = flags.z;
            MD_IDX:  take = flags.n;
            default: take = ~flags.c;
        endcase
    end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] x;
        flags_t            f;
    } regs_t;

    regs_t q, d;

    op_e               op;
    mode_e             md;
    logic [ADDR_W-1:0] ea, rel_target;
    logic [DATA_W-1:0] alu_res;
    logic              alu_c, alu_wr_a, alu_wr_x;
    logic              take;
    logic              reads_mem;
    logic              exec_now;

    assign op = op_e'(q.ir[DATA_W-1 -: 3]);
    assign md = mode_e'(q.ir[DATA_W-4 -: 2]);

    cpu8_agu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agu (
        .mode       (md),
        .hi_bits    (q.ir[HI_W-1:0]),
        .lo_byte    (mem_rdata),
        .index      (q.x),
        .next_pc    (q.pc),
        .ea         (ea),
        .rel_target (rel_target)
    );

    cpu8_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (op),
        .acc     (q.a),
        .operand (mem_rdata),
        .c_in    (q.f.c),
        .result  (alu_res),
        .c_out   (alu_c),
        .wr_acc  (alu_wr_a),
        .wr_idx  (alu_wr_x)
    );

    cpu8_cond u_cond (
        .sel   (md),
        .flags (q.f),
        .take  (take)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_we    = 1'b0;
        mem_wdata = (op == OP_STX) ? q.x : q.a;
        reads_mem = (op inside {OP_LDA, OP_LDX, OP_ADD, OP_NOR});
        exec_now  = 1'b0;

        case (q.st)
            ST_FETCH: begin
                d.pc = q.pc + 1'b1;
                d.st = ST_OPCODE;
            end
            ST_OPCODE: begin
                d.ir = mem_rdata;
                d.pc = q.pc + 1'b1;
                d.st = ST_ADDR;
            end
            ST_ADDR: begin
                mem_addr = ea;
                d.st     = ST_FETCH;
                case (op)
                    OP_STA, OP_STX: mem_we = (md != MD_IMM);
                    OP_BRC:         if (take) d.pc = rel_target;
                    OP_JMP:         d.pc = ea;
                    default: begin
                        if (md == MD_IMM) exec_now = 1'b1;
                        else              d.st = ST_DATA;
                    end
                endcase
            end
            default: begin
                exec_now = 1'b1;
                d.st     = ST_FETCH;
            end
        endcase

        if (exec_now && reads_mem) begin
            if (alu_wr_a) d.a = alu_res;
            if (alu_wr_x) d.x = alu_res;
            d.f.z = (alu_res == '0);
            d.f.n = alu_res[DATA_W-1];
            d.f.c = alu_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_FETCH) |=> (q.pc == ADDR_W'($past(q.pc) + 1'b1)));

    // R5
    zn_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_now && alu_wr_a) |=> ((q.f.z == (q.a == '0)) && (q.f.n == q.a[DATA_W-1])));

    // R5
    zn_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_now && alu_wr_x) |=> ((q.f.z == (q.x == '0)) && (q.f.n == q.x[DATA_W-1])));

    // R6
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_now && op == OP_ADD) |=>
        ({q.f.c, q.a} == $past({1'b0, q.a}) + $past({1'b0, mem_rdata})));

    // R8
    store_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> ($stable(q.f) && $stable(q.a) && $stable(q.x)));

    // R9
    branch_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_ADDR && op == OP_BRC) |=> $stable(q.f));

endmodule

// File: tb/tb_cpu8_core.sv
module tb_cpu8_core;
    localparam int AW   = 11;
    localparam int DW   = 8;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          load = 1'b0;

    always #10 clk = ~clk;

    cpu8_core #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    logic [DW-1:0] img  [MEMN];
    logic [DW-1:0] dmem [MEMN];
    logic [DW-1:0] smem [MEMN];

    always @(posedge clk) begin
        if (load) dmem <= img;
        else if (mem_we) dmem[mem_addr] <= mem_wdata;
        mem_rdata <= dmem[mem_addr];
    end

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    int    ra, rx, rpc;
    bit    fz, fn, fc;
    string src_a, src_x;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input int v);
        img[a] = v[7:0];
    endtask

    function automatic int sext8(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // R1: hold reset, load the image, release and check reset outputs
    task automatic start_run();
        rst = 1'b1;
        load = 1'b1;
        smem = img;
        @(negedge clk);
        load = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_we == 1'b0, "R1 no write in reset", mem_we, 0);
        ra = 0; rx = 0; rpc = 0; fz = 0; fn = 0; fc = 0;
        src_a = "R1"; src_x = "R1";
        rst = 1'b0;
        #1;
    endtask

    task automatic run(input int n_instr);
        string ftag = "R1 first fetch";
        for (int i = 0; i < n_instr; i++) begin
            int pc0, b, o, op, md, absa, idxa, rela, ea, data, dur, sum;
            bit wexp;
            int wa, wd;
            string wsrc;
            pc0  = rpc;
            b    = smem[pc0];
            o    = smem[(pc0 + 1) % MEMN];
            op   = b >> 5;
            md   = (b >> 3) & 3;
            absa = ((b & 7) << 8) | o;
            idxa = (absa + rx) % MEMN;
            rela = (pc0 + 2 + sext8(o) + MEMN) % MEMN;
            ea   = (md == 2) ? idxa : (md == 3) ? rela : absa;
            data = (md == 0) ? o : smem[ea];
            dur  = (op <= 3 && md != 0) ? 4 : 3;
            wexp = (op == 4 || op == 5) && md != 0;
            wa   = ea;
            wd   = (op == 5) ? rx : ra;
            wsrc = (op == 5) ? src_x : src_a;

            chk(mem_addr == AW'(pc0), ftag, mem_addr, pc0);
            for (int c = 0; c < dur; c++) begin
                if (c == 2 && wexp) begin
                    chk(mem_we == 1'b1, "R8 write strobe", mem_we, 1);
                    chk(mem_addr == AW'(wa), "R4 store address", mem_addr, wa);
                    chk(mem_wdata == DW'(wd), {"R8 store data from ", wsrc}, mem_wdata, wd);
                end else if (c == 2 && (op == 4 || op == 5)) begin
                    chk(mem_we == 1'b0, "R8 immediate store writes nothing", mem_we, 0);
                end else begin
                    chk(mem_we == 1'b0, "R3 no write outside store cycle", mem_we, 0);
                end
                @(negedge clk);
            end

            rpc  = (pc0 + 2) % MEMN;
            ftag = "R2 sequential fetch";
            case (op)
                0: begin ra = data; fz = (data == 0); fn = data[7]; src_a = "R5 load"; end
                1: begin rx = data; fz = (data == 0); fn = data[7]; src_x = "R5 load"; end
                2: begin
                    sum = ra + data; fc = sum[8]; ra = sum & 255;
                    fz = (ra == 0); fn = ra[7]; src_a = "R6 add";
                end
                3: begin
                    ra = (~(ra | data)) & 255; fz = (ra == 0); fn = ra[7]; src_a = "R7 nor";
                end
                4, 5: if (wexp) smem[wa] = wd[7:0];
                6: begin
                    bit t;
                    t = (md == 0) || (md == 1 && fz) || (md == 2 && fn) || (md == 3 && !fc);
                    if (t) rpc = rela;
                    ftag = "R9 branch outcome";
                end
                default: begin rpc = ea; ftag = "R10 jump target"; end
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'h0000_1d2b));

        // Directed: indexed wrap, carry, immediate store, each branch test
        for (int a = 0; a < MEMN; a++) img[a] = '0;
        put(12'h0FE, 8'h80);
        put(0,  8'h20); put(1,  8'hFF);
        put(2,  8'h17); put(3,  8'hFF);
        put(4,  8'h89); put(5,  8'h00);
        put(6,  8'h40); put(7,  8'h80);
        put(8,  8'h80); put(9,  8'h55);
        put(10, 8'h89); put(11, 8'h01);
        put(12, 8'hD8); put(13, 8'h10);
        put(14, 8'hC8); put(15, 8'h02);
        put(16, 8'hA9); put(17, 8'h02);
        put(18, 8'h60); put(19, 8'h0F);
        put(20, 8'hD0); put(21, 8'h02);
        put(24, 8'h48); put(25, 8'hFE);
        put(26, 8'hB7); put(27, 8'h00);
        put(28, 8'hE9); put(29, 8'h00);
        start_run();
        run(60);

        // Directed: backward relative wrap, immediate jump, relative jump
        for (int a = 0; a < MEMN; a++) img[a] = '0;
        put(0,       8'hC0); put(1,       8'hF0);
        put(12'h7F4, 8'hE3); put(12'h7F5, 8'h21);
        put(12'h321, 8'hF8); put(12'h322, 8'h00);
        put(12'h325, 8'hB9); put(12'h326, 8'hFF);
        start_run();
        run(40);

        // Random images
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < MEMN; a++) img[a] = DW'($urandom());
            start_run();
            run(2500);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule